// File: doc/BRIEF.md
# Audio Serial Port Control and Status Registers

This block is the software-facing register file of a stereo audio serial port. A host reaches it over a simple single-cycle bus: a write strobe updates state on the rising clock edge, and read data is returned combinationally in the same cycle as the read strobe. The bus never stalls, so there is no back-pressure: every strobed access is accepted in the cycle it is presented. The block exposes the receiver, transmitter and clock enables, a 32-bit mode word, and one interrupt line to the serial datapath and to the interrupt controller.

Enables and interrupt masks are never written directly. Each has a pair of write-one-to-act command registers, one that sets and one that clears, so that software never needs a read-modify-write. Receive-overrun and transmit-underrun errors arrive from the datapath as one-cycle pulses, one per channel. Each pulse latches both a summary flag and a per-channel flag. These flags stay set until software clears them, and software may also set them on purpose to exercise the interrupt path. The receive-ready and transmit-ready levels from the datapath are shown live in the status word.

Top module: `asp_regs`

## Requirements
- R1: After reset, rx_on, tx_on, clk_on, irq and mode_cfg are 0, and the status (0x08), mode (0x04) and interrupt mask (0x1C) registers read as 0.
- R2: A write to the command register at 0x00 with bit 0, bit 2 or bit 4 set turns on the receiver, the clocks or the transmitter respectively. Bit 1, bit 3 or bit 5 turns the same function off. A zero in any of these bits leaves its function unchanged.
- R3: When a single command write sets both the enable bit and the disable bit of one function, that function ends up off.
- R4: The mode register at 0x04 is 32 bits, read-write, reads back what was last written, and drives mode_cfg from the cycle after the write.
- R5: The status register at 0x08 reads bit 0 = receiver on, bit 1 = rx_rdy_i, bit 2 = receive overrun, bit 4 = transmitter on, bit 5 = tx_rdy_i, bit 6 = transmit underrun, bits 8+c = receive overrun of channel c, and bits 20+c = transmit underrun of channel c. All other bits read 0.
- R6: A one-cycle pulse on rx_ovr_ev[c] or tx_udr_ev[c] sets the matching summary flag and the matching channel-c flag from the next cycle. Each flag then stays set with no further pulse.
- R7: Writing a one at bit 2, bit 6, bits 9:8 or bits 21:20 of the status-clear register at 0x0C clears the matching flag. Flags whose bit is written as zero are left unchanged.
- R8: Writing a one at bit 2, bit 6, bits 9:8 or bits 21:20 of the status-set register at 0x10 sets the matching flag.
- R9: A hardware error pulse in the same cycle as a clear write to its flag leaves that flag set.
- R10: Writing ones to 0x14 sets, and writing ones to 0x18 clears, interrupt mask bits 1 (receive ready), 2 (overrun), 5 (transmit ready) and 6 (underrun). The mask reads back at 0x1C in the same bit positions.
- R11: irq is 1 exactly when, for some bit in {1, 2, 5, 6}, both the status bit and the mask bit are 1.
- R12: Reads of 0x00, 0x0C, 0x10, 0x14, 0x18 and of unmapped addresses return 0. Writes to the read-only registers 0x08 and 0x1C change nothing.
- R13: A command write with bit 7 set returns every enable, mask bit, error flag and the mode word to 0 in the next cycle. This overrides any other bit in the same write and any error pulse in the same cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_sel | input | 1 | Access strobe |
| bus_wr | input | 1 | 1 = write, 0 = read |
| bus_addr | input | ADDR_W | Byte address |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data, valid in the strobe cycle of a read, 0 otherwise |
| rx_rdy_i | input | 1 | Receive-ready level from the datapath |
| tx_rdy_i | input | 1 | Transmit-ready level from the datapath |
| rx_ovr_ev | input | NCH | Per-channel receive overrun pulses |
| tx_udr_ev | input | NCH | Per-channel transmit underrun pulses |
| rx_on | output | 1 | Receiver enable |
| tx_on | output | 1 | Transmitter enable |
| clk_on | output | 1 | Serial clock enable |
| mode_cfg | output | 32 | Current mode word |
| irq | output | 1 | Interrupt request |

## Verification
The bench targets the races and priorities. It writes enable and disable for one function in the same write; a design that let the set win would leave that function running. It fires an overrun pulse in the same cycle as a clear of that flag; a design that let software win would lose the error. It issues a software reset together with enable bits; a design that honoured the enables would come out of reset still running. The bench also checks that summary and per-channel flags are cleared independently, that writes to read-only addresses and reads of command addresses have no effect and return zero, and that irq follows the live ready inputs only through the mask.

// File: rtl/asp_pkg.sv
package asp_pkg;
  localparam int DW = 32;

  // register byte offsets
  localparam logic [7:0] OFS_CMD  = 8'h00;
  localparam logic [7:0] OFS_MODE = 8'h04;
  localparam logic [7:0] OFS_STAT = 8'h08;
  localparam logic [7:0] OFS_SCLR = 8'h0C;
  localparam logic [7:0] OFS_SSET = 8'h10;
  localparam logic [7:0] OFS_IEN  = 8'h14;
  localparam logic [7:0] OFS_IDIS = 8'h18;
  localparam logic [7:0] OFS_IMSK = 8'h1C;

  // command bits
  localparam int CB_RX_ON  = 0;
  localparam int CB_RX_OFF = 1;
  localparam int CB_CK_ON  = 2;
  localparam int CB_CK_OFF = 3;
  localparam int CB_TX_ON  = 4;
  localparam int CB_TX_OFF = 5;
  localparam int CB_SRST   = 7;

  // status / interrupt bit positions
  localparam int SB_RXEN  = 0;
  localparam int SB_RXRDY = 1;
  localparam int SB_RXOR  = 2;
  localparam int SB_TXEN  = 4;
  localparam int SB_TXRDY = 5;
  localparam int SB_TXUR  = 6;
  localparam int SB_RXCH  = 8;
  localparam int SB_TXCH  = 20;

  typedef enum logic [3:0] {
    SEL_NONE, SEL_CMD, SEL_MODE, SEL_STAT, SEL_SCLR,
    SEL_SSET, SEL_IEN, SEL_IDIS, SEL_IMSK
  } reg_sel_e;
endpackage

// File: rtl/asp_flag_bank.sv
module asp_flag_bank #(
  parameter int W = 4
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         srst,
  input  logic [W-1:0] set,
  input  logic [W-1:0] clr,
  input  logic [W-1:0] frc,
  output logic [W-1:0] q
);
  logic [W-1:0] nxt;

  // clear beats software set, forced (hardware) set beats clear
  always_comb nxt = frc | ((q | set) & ~clr);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)    q <= '0;
    else if (srst) q <= '0;
    else           q <= nxt;
  end
endmodule

// File: rtl/asp_irq_comb.sv
module asp_irq_comb #(
  parameter int N = 4
) (
  input  logic [N-1:0] src,
  input  logic [N-1:0] msk,
  output logic         irq
);
  always_comb irq = |(src & msk);
endmodule

// File: rtl/asp_regs.sv
module asp_regs
  import asp_pkg::*;
#(
  parameter int ADDR_W = 8,
  parameter int NCH    = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              bus_sel,
  input  logic              bus_wr,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic [DW-1:0]     bus_wdata,
  output logic [DW-1:0]     bus_rdata,
  input  logic              rx_rdy_i,
  input  logic              tx_rdy_i,
  input  logic [NCH-1:0]    rx_ovr_ev,
  input  logic [NCH-1:0]    tx_udr_ev,
  output logic              rx_on,
  output logic              tx_on,
  output logic              clk_on,
  output logic [DW-1:0]     mode_cfg,
  output logic              irq
);
  localparam int EW = 2 + 2 * NCH; // [0] rx sum, [1] tx sum, rx chans, tx chans
  localparam int CW = 3;           // [0] rx, [1] clk, [2] tx
  localparam int MW = 4;           // [0] rxrdy, [1] rxor, [2] txrdy, [3] txur

  reg_sel_e sel;
  always_comb begin
    sel = SEL_NONE;
    if (bus_sel) begin
      case (bus_addr)
        ADDR_W'(OFS_CMD):  sel = SEL_CMD;
        ADDR_W'(OFS_MODE): sel = SEL_MODE;
        ADDR_W'(OFS_STAT): sel = SEL_STAT;
        ADDR_W'(OFS_SCLR): sel = SEL_SCLR;
        ADDR_W'(OFS_SSET): sel = SEL_SSET;
        ADDR_W'(OFS_IEN):  sel = SEL_IEN;
        ADDR_W'(OFS_IDIS): sel = SEL_IDIS;
        ADDR_W'(OFS_IMSK): sel = SEL_IMSK;
        default:           sel = SEL_NONE;
      endcase
    end
  end

  logic wr, srst;
  assign wr   = bus_sel && bus_wr;
  assign srst = wr && (sel == SEL_CMD) && bus_wdata[CB_SRST];

  // enables
  logic [CW-1:0] en_set, en_clr, en_q;
  always_comb begin
    en_set = '0;
    en_clr = '0;
    if (wr && sel == SEL_CMD) begin
      en_set = {bus_wdata[CB_TX_ON],  bus_wdata[CB_CK_ON],  bus_wdata[CB_RX_ON]};
      en_clr = {bus_wdata[CB_TX_OFF], bus_wdata[CB_CK_OFF], bus_wdata[CB_RX_OFF]};
    end
  end

  asp_flag_bank #(.W(CW)) u_en (
    .clk(clk), .rst_n(rst_n), .srst(srst),
    .set(en_set), .clr(en_clr), .frc('0), .q(en_q)
  );

  // interrupt mask
  logic [MW-1:0] msk_pick, msk_set, msk_clr, msk_q;
  assign msk_pick = {bus_wdata[SB_TXUR], bus_wdata[SB_TXRDY],
                     bus_wdata[SB_RXOR], bus_wdata[SB_RXRDY]};
  assign msk_set  = (wr && sel == SEL_IEN)  ? msk_pick : '0;
  assign msk_clr  = (wr && sel == SEL_IDIS) ? msk_pick : '0;

  asp_flag_bank #(.W(MW)) u_msk (
    .clk(clk), .rst_n(rst_n), .srst(srst),
    .set(msk_set), .clr(msk_clr), .frc('0), .q(msk_q)
  );

  // sticky error flags
  logic [EW-1:0] err_pick, err_set, err_clr, err_hw, err_q;
  assign err_pick = {bus_wdata[SB_TXCH +: NCH], bus_wdata[SB_RXCH +: NCH],
                     bus_wdata[SB_TXUR], bus_wdata[SB_RXOR]};
  assign err_set  = (wr && sel == SEL_SSET) ? err_pick : '0;
  assign err_clr  = (wr && sel == SEL_SCLR) ? err_pick : '0;
  assign err_hw   = {tx_udr_ev, rx_ovr_ev, |tx_udr_ev, |rx_ovr_ev};

  asp_flag_bank #(.W(EW)) u_err (
    .clk(clk), .rst_n(rst_n), .srst(srst),
    .set(err_set), .clr(err_clr), .frc(err_hw), .q(err_q)
  );

  // mode word
  logic [DW-1:0] mode_q;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                      mode_q <= '0;
    else if (srst)                   mode_q <= '0;
    else if (wr && sel == SEL_MODE)  mode_q <= bus_wdata;
  end

  // status and mask words
  logic [DW-1:0] stat_w, msk_w;
  always_comb begin
    stat_w = '0;
    stat_w[SB_RXEN]  = en_q[0];
    stat_w[SB_RXRDY] = rx_rdy_i;
    stat_w[SB_RXOR]  = err_q[0];
    stat_w[SB_TXEN]  = en_q[2];
    stat_w[SB_TXRDY] = tx_rdy_i;
    stat_w[SB_TXUR]  = err_q[1];
    stat_w[SB_RXCH +: NCH] = err_q[2 +: NCH];
    stat_w[SB_TXCH +: NCH] = err_q[2 + NCH +: NCH];
    msk_w = '0;
    msk_w[SB_RXRDY] = msk_q[0];
    msk_w[SB_RXOR]  = msk_q[1];
    msk_w[SB_TXRDY] = msk_q[2];
    msk_w[SB_TXUR]  = msk_q[3];
  end

  always_comb begin
    bus_rdata = '0;
    if (!bus_wr) begin
      case (sel)
        SEL_MODE: bus_rdata = mode_q;
        SEL_STAT: bus_rdata = stat_w;
        SEL_IMSK: bus_rdata = msk_w;
        default:  bus_rdata = '0;
      endcase
    end
  end

  asp_irq_comb #(.N(MW)) u_irq (
    .src({err_q[1], tx_rdy_i, err_q[0], rx_rdy_i}),
    .msk(msk_q),
    .irq(irq)
  );

  assign rx_on    = en_q[0];
  assign clk_on   = en_q[1];
  assign tx_on    = en_q[2];
  assign mode_cfg = mode_q;
endmodule

// File: rtl/asp_regs_chk.sv
module asp_regs_chk
  import asp_pkg::*;
#(
  parameter int ADDR_W = 8,
  parameter int NCH    = 2
) (
  input logic              clk,
  input logic              rst_n,
  input logic              bus_sel,
  input logic              bus_wr,
  input logic [ADDR_W-1:0] bus_addr,
  input logic [DW-1:0]     bus_wdata,
  input logic [NCH-1:0]    rx_ovr_ev,
  input logic [NCH-1:0]    tx_udr_ev,
  input logic              rx_on,
  input logic              tx_on,
  input logic              clk_on,
  input logic [DW-1:0]     mode_cfg,
  input logic              irq,
  input logic [3:0]        msk_q,
  input logic [2+2*NCH-1:0] err_q
);
  logic wcmd, wclr, rst_cmd;
  assign wcmd    = bus_sel && bus_wr && (bus_addr == ADDR_W'(OFS_CMD));
  assign wclr    = bus_sel && bus_wr && (bus_addr == ADDR_W'(OFS_SCLR));
  assign rst_cmd = wcmd && bus_wdata[CB_SRST];

  p_rx_enable_r2: assert property (@(posedge clk) disable iff (!rst_n)
    wcmd && bus_wdata[CB_RX_ON] && !bus_wdata[CB_RX_OFF] && !bus_wdata[CB_SRST] |=> rx_on);

  p_disable_wins_r3: assert property (@(posedge clk) disable iff (!rst_n)
    wcmd && bus_wdata[CB_TX_ON] && bus_wdata[CB_TX_OFF] |=> !tx_on);

  p_flag_sticky_r6: assert property (@(posedge clk) disable iff (!rst_n)
    err_q[0] && !(wclr && bus_wdata[SB_RXOR]) && !rst_cmd |=> err_q[0]);

  p_hw_over_clear_r9: assert property (@(posedge clk) disable iff (!rst_n)
    rx_ovr_ev[0] && !rst_cmd |=> err_q[0] && err_q[2]);

  p_hw_udr_sets_r6: assert property (@(posedge clk) disable iff (!rst_n)
    tx_udr_ev[0] && !rst_cmd |=> err_q[1]);

  p_masked_quiet_r11: assert property (@(posedge clk) disable iff (!rst_n)
    (msk_q == 4'b0) |-> !irq);

  p_soft_reset_r13: assert property (@(posedge clk) disable iff (!rst_n)
    rst_cmd |=> !rx_on && !tx_on && !clk_on && (mode_cfg == '0) &&
                (msk_q == 4'b0) && (err_q == '0));
endmodule

bind asp_regs asp_regs_chk #(.ADDR_W(ADDR_W), .NCH(NCH)) u_chk (.*);

// File: tb/tb_asp_regs.sv
`timescale 1ns/1ps
module tb_asp_regs;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        bus_sel = 1'b0, bus_wr = 1'b0;
  logic [7:0]  bus_addr = '0;
  logic [31:0] bus_wdata = '0;
  logic [31:0] bus_rdata;
  logic        rx_rdy_i = 1'b0, tx_rdy_i = 1'b0;
  logic [1:0]  rx_ovr_ev = '0, tx_udr_ev = '0;
  logic        rx_on, tx_on, clk_on, irq;
  logic [31:0] mode_cfg;

  int checks = 0;
  int errors = 0;
  bit done = 0;

  always #2.5 clk = ~clk;

  asp_regs dut (
    .clk(clk), .rst_n(rst_n), .bus_sel(bus_sel), .bus_wr(bus_wr),
    .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
    .rx_rdy_i(rx_rdy_i), .tx_rdy_i(tx_rdy_i), .rx_ovr_ev(rx_ovr_ev),
    .tx_udr_ev(tx_udr_ev), .rx_on(rx_on), .tx_on(tx_on), .clk_on(clk_on),
    .mode_cfg(mode_cfg), .irq(irq)
  );

  task automatic chk(input string tag, input logic [31:0] got, input logic [31:0] exp);
    checks++;
    if (got !== exp) begin
      errors++;
      $display("FAIL %s got=%h exp=%h", tag, got, exp);
    end
  endtask

  task automatic wr(input logic [7:0] a, input logic [31:0] d);
    @(negedge clk);
    bus_sel = 1'b1; bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
    @(negedge clk);
    bus_sel = 1'b0; bus_wr = 1'b0; bus_wdata = '0;
  endtask

  task automatic rd(input logic [7:0] a, output logic [31:0] d);
    @(negedge clk);
    bus_sel = 1'b1; bus_wr = 1'b0; bus_addr = a;
    #1 d = bus_rdata;
    bus_sel = 1'b0;
  endtask

  task automatic t_reset();
    logic [31:0] d;
    chk("R1 enables", {29'd0, rx_on, tx_on, clk_on}, 32'd0);
    chk("R1 irq", {31'd0, irq}, 32'd0);
    chk("R1 mode_cfg", mode_cfg, 32'd0);
    rd(8'h08, d); chk("R1 status", d, 32'd0);
    rd(8'h04, d); chk("R1 mode", d, 32'd0);
    rd(8'h1C, d); chk("R1 mask", d, 32'd0);
  endtask

  task automatic t_cmd();
    logic [31:0] d;
    wr(8'h00, 32'h15);
    chk("R2 all on", {29'd0, rx_on, tx_on, clk_on}, 32'd7);
    rd(8'h08, d); chk("R5 status enables", d, 32'h11);
    wr(8'h00, 32'h02);
    chk("R2 rx off only", {29'd0, rx_on, tx_on, clk_on}, 32'd3);
    wr(8'h00, 32'h00);
    chk("R2 zero write keeps", {29'd0, rx_on, tx_on, clk_on}, 32'd3);
    wr(8'h00, 32'h28);
    chk("R2 clk tx off", {29'd0, rx_on, tx_on, clk_on}, 32'd0);
  endtask

  task automatic t_conflict();
    wr(8'h00, 32'h10);
    wr(8'h00, 32'h30);
    chk("R3 tx on+off", {31'd0, tx_on}, 32'd0);
    wr(8'h00, 32'h03);
    chk("R3 rx on+off", {31'd0, rx_on}, 32'd0);
    wr(8'h00, 32'h0C);
    chk("R3 clk on+off", {31'd0, clk_on}, 32'd0);
  endtask

  task automatic t_mode();
    logic [31:0] d;
    wr(8'h04, 32'hA5C3_0F1E);
    chk("R4 mode_cfg", mode_cfg, 32'hA5C3_0F1E);
    rd(8'h04, d); chk("R4 mode read", d, 32'hA5C3_0F1E);
  endtask

  task automatic t_live();
    logic [31:0] d;
    rx_rdy_i = 1'b1; tx_rdy_i = 1'b1;
    rd(8'h08, d); chk("R5 ready levels", d, 32'h22);
    rx_rdy_i = 1'b0; tx_rdy_i = 1'b0;
    rd(8'h08, d); chk("R5 ready low", d, 32'h0);
  endtask

  task automatic t_hw_err();
    logic [31:0] d;
    @(negedge clk); rx_ovr_ev = 2'b10;
    @(negedge clk); rx_ovr_ev = 2'b00;
    rd(8'h08, d); chk("R6 rx ch1 overrun", d, 32'h204);
    @(negedge clk); tx_udr_ev = 2'b01;
    @(negedge clk); tx_udr_ev = 2'b00;
    repeat (4) @(negedge clk);
    rd(8'h08, d); chk("R6 sticky both", d, 32'h0010_0244);
  endtask

  task automatic t_clear();
    logic [31:0] d;
    wr(8'h0C, 32'h4);
    rd(8'h08, d); chk("R7 clear summary only", d, 32'h0010_0240);
    wr(8'h0C, 32'hFFFF_FFFF);
    rd(8'h08, d); chk("R7 clear all", d, 32'h0);
  endtask

  task automatic t_set();
    logic [31:0] d;
    wr(8'h10, 32'h0030_0344);
    rd(8'h08, d); chk("R8 set flags", d, 32'h0030_0344);
    wr(8'h0C, 32'hFFFF_FFFF);
  endtask

  task automatic t_race();
    logic [31:0] d;
    @(negedge clk);
    bus_sel = 1'b1; bus_wr = 1'b1; bus_addr = 8'h0C; bus_wdata = 32'h304;
    rx_ovr_ev = 2'b01;
    @(negedge clk);
    bus_sel = 1'b0; bus_wr = 1'b0; bus_wdata = '0; rx_ovr_ev = 2'b00;
    rd(8'h08, d); chk("R9 event beats clear", d, 32'h104);
    wr(8'h0C, 32'hFFFF_FFFF);
  endtask

  task automatic t_mask();
    logic [31:0] d;
    wr(8'h14, 32'hFFFF_FFFF);
    rd(8'h1C, d); chk("R10 mask all", d, 32'h66);
    wr(8'h18, 32'h22);
    rd(8'h1C, d); chk("R10 mask partial", d, 32'h44);
    wr(8'h1C, 32'hFF);
    rd(8'h1C, d); chk("R12 mask ro write", d, 32'h44);
    wr(8'h08, 32'hFFFF_FFFF);
    rd(8'h08, d); chk("R12 status ro write", d, 32'h0);
  endtask

  task automatic t_irq();
    rx_rdy_i = 1'b1;
    #1 chk("R11 rxrdy masked", {31'd0, irq}, 32'd0);
    wr(8'h10, 32'h4);
    chk("R11 overrun irq", {31'd0, irq}, 32'd1);
    wr(8'h0C, 32'h4);
    chk("R11 overrun cleared", {31'd0, irq}, 32'd0);
    wr(8'h14, 32'h2);
    chk("R11 rxrdy unmasked", {31'd0, irq}, 32'd1);
    rx_rdy_i = 1'b0;
    #1 chk("R11 rxrdy dropped", {31'd0, irq}, 32'd0);
    wr(8'h0C, 32'hFFFF_FFFF);
  endtask

  task automatic t_wo_read();
    logic [31:0] d;
    wr(8'h10, 32'h0030_0344);
    wr(8'h00, 32'h15);
    rd(8'h00, d); chk("R12 cmd reads 0", d, 32'h0);
    rd(8'h0C, d); chk("R12 clr reads 0", d, 32'h0);
    rd(8'h10, d); chk("R12 set reads 0", d, 32'h0);
    rd(8'h14, d); chk("R12 ien reads 0", d, 32'h0);
    rd(8'h18, d); chk("R12 idis reads 0", d, 32'h0);
    rd(8'h40, d); chk("R12 unmapped reads 0", d, 32'h0);
  endtask

  task automatic t_swrst();
    logic [31:0] d;
    wr(8'h04, 32'h1234_5678);
    @(negedge clk);
    bus_sel = 1'b1; bus_wr = 1'b1; bus_addr = 8'h00; bus_wdata = 32'h95;
    tx_udr_ev = 2'b10;
    @(negedge clk);
    bus_sel = 1'b0; bus_wr = 1'b0; bus_wdata = '0; tx_udr_ev = 2'b00;
    chk("R13 enables off", {29'd0, rx_on, tx_on, clk_on}, 32'd0);
    chk("R13 mode_cfg", mode_cfg, 32'h0);
    chk("R13 irq", {31'd0, irq}, 32'd0);
    rd(8'h08, d); chk("R13 status", d, 32'h0);
    rd(8'h1C, d); chk("R13 mask", d, 32'h0);
    rd(8'h04, d); chk("R13 mode read", d, 32'h0);
  endtask

  initial begin
    #(200000 * 5);
    if (!done) begin
      errors++;
      $display("FAIL watchdog got=timeout exp=completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    t_reset();
    rst_n = 1'b1;
    repeat (2) @(negedge clk);
    t_reset();
    t_cmd();
    t_conflict();
    t_mode();
    t_live();
    t_hw_err();
    t_clear();
    t_set();
    t_race();
    t_mask();
    t_irq();
    t_wo_read();
    t_swrst();
    done = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule